// File: doc/BRIEF.md
# Thread/Handler Privilege Tracker

This block follows a processor core's operating mode and privilege level. The mode is either thread, for application code, or handler, for exception code. The privilege level of thread code is either user or privileged. From these it drives the privilege attribute that accompanies every bus transfer the core issues, so that downstream protection logic can tell user accesses from privileged ones.

Four kinds of strobe drive it:

- exception entry;
- exception return;
- a supervisor call carrying an index;
- a write of the control bit that requests unprivileged thread execution.

Thread code may give up its privilege with a control write. It cannot take privilege back that way. The only route back to privileged thread execution is a supervisor call with the raise index, which passes through handler mode. Only one level of handler state is kept. The thread privilege stored before entry is the value restored on return.

All state is registered. Every strobe seen on a rising clock edge takes effect on the outputs right after that edge.

Top module: `thrpriv_fsm`

## Requirements
- R1: After reset the outputs show thread mode (`mode_o`=0), privileged thread level (`thread_priv_o`=1), `priv_o`=1 and `fault_o`=0.
- R2: While `mode_o`=1 (handler), `priv_o` is 1.
- R3: An exception-entry strobe in thread mode puts the block into handler mode after the edge and leaves `thread_priv_o` unchanged. An exception-return strobe in handler mode puts it back into thread mode with `thread_priv_o` unchanged.
- R4: In privileged thread mode, a control write with `ctl_unpriv_i`=1 clears `thread_priv_o` to 0 (user). A control write with `ctl_unpriv_i`=0 keeps it at 1.
- R5: In user thread mode, a control write leaves `thread_priv_o` at 0 and raises `fault_o` for exactly the one cycle after the write edge.
- R6: A supervisor call with index `RAISE_IDX` (default 2) from thread mode enters handler mode and sets `thread_priv_o` to 1. The following return therefore lands in privileged thread mode.
- R7: A supervisor call with any other index from thread mode enters handler mode without changing `thread_priv_o`.
- R8: In thread mode, `priv_o` equals `thread_priv_o`.
- R9: In handler mode, a control write sets `thread_priv_o` to the inverse of `ctl_unpriv_i` and never raises `fault_o`.
- R10: Ordering rules:
  - In thread mode, an entry or supervisor call in the same cycle as a control write wins. The write is dropped without a fault.
  - In handler mode, a return wins over a simultaneous control write.
  - Entry and supervisor-call strobes in handler mode are ignored.
  - A return strobe in thread mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_entry_i | input | 1 | Exception-entry strobe |
| exc_return_i | input | 1 | Exception-return strobe |
| svc_i | input | 1 | Supervisor-call strobe |
| svc_idx_i | input | IDX_W | Supervisor-call index |
| ctl_wr_i | input | 1 | Control-register write strobe |
| ctl_unpriv_i | input | 1 | Written unprivileged bit (1 = user thread) |
| mode_o | output | 1 | Current mode, 1 = handler, 0 = thread |
| priv_o | output | 1 | Bus privilege attribute, 1 = privileged |
| thread_priv_o | output | 1 | Stored thread privilege, 1 = privileged |
| fault_o | output | 1 | One-cycle pulse after a refused control write |

## Verification
The assertions watch several rules on every cycle:

- the privilege attribute is forced high in handler mode and tracks the stored thread level in thread mode;
- a user thread never regains privilege without passing through handler mode;
- a return keeps the stored level;
- a supervisor call with a non-raise index preserves that level;
- every fault pulse traces back to a refused write.

Only the bench scenarios can show the rest. These are the full round trips through handler mode, the raise by the privileged index, control writes made from inside a handler, and the ordering rules for strobes that collide in the same cycle. Long random strobe mixes are compared against a bench model.

// File: rtl/thrpriv_pkg.sv
package thrpriv_pkg;

    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_ENTER      = 3'd1,
        EV_ENTER_RISE = 3'd2,
        EV_RETURN     = 3'd3,
        EV_CTL_SET    = 3'd4,
        EV_CTL_DENIED = 3'd5
    } event_e;

    typedef struct packed {
        mode_e mode;
        logic  thread_priv;
        logic  fault;
    } core_state_t;

    localparam core_state_t CORE_RESET = '{mode: MODE_THREAD, thread_priv: 1'b1, fault: 1'b0};

endpackage

// File: rtl/thrpriv_event_decode.sv
module thrpriv_event_decode
    import thrpriv_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int RAISE_IDX = 2
) (
    input  mode_e            mode_i,
    input  logic             thread_priv_i,
    input  logic             exc_entry_i,
    input  logic             exc_return_i,
    input  logic             svc_i,
    input  logic [IDX_W-1:0] svc_idx_i,
    input  logic             ctl_wr_i,
    output event_e           ev_o
);

    localparam logic [IDX_W-1:0] RAISE_CODE = IDX_W'(RAISE_IDX);

    logic svc_raise;
    logic go_handler;

    always_comb begin
        svc_raise  = svc_i && (svc_idx_i == RAISE_CODE);
        go_handler = svc_i || exc_entry_i;
        ev_o       = EV_NONE;
        if (mode_i == MODE_THREAD) begin
            // Mode changes outrank control writes in thread mode
            if (svc_raise) begin
                ev_o = EV_ENTER_RISE;
            end else if (go_handler) begin
                ev_o = EV_ENTER;
            end else if (ctl_wr_i) begin
                ev_o = thread_priv_i ? EV_CTL_SET : EV_CTL_DENIED;
            end
        end else begin
            // Single handler level: entry and calls are not nested
            if (exc_return_i) begin
                ev_o = EV_RETURN;
            end else if (ctl_wr_i) begin
                ev_o = EV_CTL_SET;
            end
        end
    end

endmodule

// File: rtl/thrpriv_core.sv
module thrpriv_core
    import thrpriv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  event_e      ev_i,
    input  logic        ctl_unpriv_i,
    output core_state_t state_o
);

    core_state_t state_d;
    core_state_t state_q;

    always_comb begin
        state_d       = state_q;
        state_d.fault = 1'b0;
        unique case (ev_i)
            EV_ENTER: begin
                state_d.mode = MODE_HANDLER;
            end
            EV_ENTER_RISE: begin
                state_d.mode        = MODE_HANDLER;
                state_d.thread_priv = 1'b1;
            end
            EV_RETURN: begin
                state_d.mode = MODE_THREAD;
            end
            EV_CTL_SET: begin
                state_d.thread_priv = ~ctl_unpriv_i;
            end
            EV_CTL_DENIED: begin
                state_d.fault = 1'b1;
            end
            default: begin
                state_d.fault = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CORE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/thrpriv_attr.sv
module thrpriv_attr
    import thrpriv_pkg::*;
(
    input  core_state_t state_i,
    output logic        mode_o,
    output logic        priv_o,
    output logic        thread_priv_o,
    output logic        fault_o
);

    always_comb begin
        mode_o        = (state_i.mode == MODE_HANDLER);
        priv_o        = (state_i.mode == MODE_HANDLER) ? 1'b1 : state_i.thread_priv;
        thread_priv_o = state_i.thread_priv;
        fault_o       = state_i.fault;
    end

endmodule

// File: rtl/thrpriv_fsm.sv
module thrpriv_fsm
    import thrpriv_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int RAISE_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_entry_i,
    input  logic             exc_return_i,
    input  logic             svc_i,
    input  logic [IDX_W-1:0] svc_idx_i,
    input  logic             ctl_wr_i,
    input  logic             ctl_unpriv_i,
    output logic             mode_o,
    output logic             priv_o,
    output logic             thread_priv_o,
    output logic             fault_o
);

    localparam logic [IDX_W-1:0] RAISE_CODE = IDX_W'(RAISE_IDX);

    event_e      ev;
    core_state_t state;

    thrpriv_event_decode #(
        .IDX_W     (IDX_W),
        .RAISE_IDX (RAISE_IDX)
    ) i_decode (
        .mode_i        (state.mode),
        .thread_priv_i (state.thread_priv),
        .exc_entry_i   (exc_entry_i),
        .exc_return_i  (exc_return_i),
        .svc_i         (svc_i),
        .svc_idx_i     (svc_idx_i),
        .ctl_wr_i      (ctl_wr_i),
        .ev_o          (ev)
    );

    thrpriv_core i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_i         (ev),
        .ctl_unpriv_i (ctl_unpriv_i),
        .state_o      (state)
    );

    thrpriv_attr i_attr (
        .state_i       (state),
        .mode_o        (mode_o),
        .priv_o        (priv_o),
        .thread_priv_o (thread_priv_o),
        .fault_o       (fault_o)
    );

    // R2: handler code always carries the privileged attribute
    a_r2_handler_priv : assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> priv_o);

    // R8: thread attribute follows the stored level
    a_r8_thread_attr : assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |-> (priv_o == thread_priv_o));

    // R5: a user thread without entry or call stays user
    a_r5_no_self_raise : assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && !thread_priv_o && !exc_entry_i && !svc_i) |=> !thread_priv_o);

    // R3: return restores thread mode and keeps the stored level
    a_r3_return_keeps : assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o && exc_return_i) |=> (!mode_o && $stable(thread_priv_o)));

    // R7: other call indices keep the stored level
    a_r7_svc_keep : assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && svc_i && (svc_idx_i != RAISE_CODE)) |=> (mode_o && $stable(thread_priv_o)));

    // R5: a fault traces back to a refused user-thread write
    a_r5_fault_cause : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(!mode_o && !thread_priv_o && ctl_wr_i && !exc_entry_i && !svc_i));

endmodule

// File: tb/test_thrpriv_fsm.sv
`timescale 1ns/1ps
module test_thrpriv_fsm;

    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exc_entry_i = 1'b0;
    logic             exc_return_i = 1'b0;
    logic             svc_i = 1'b0;
    logic [IDX_W-1:0] svc_idx_i = '0;
    logic             ctl_wr_i = 1'b0;
    logic             ctl_unpriv_i = 1'b0;
    logic             mode_o;
    logic             priv_o;
    logic             thread_priv_o;
    logic             fault_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // bench model
    logic m_mode = 1'b0;
    logic m_tp = 1'b1;
    logic m_fault = 1'b0;

    always #5 clk = ~clk;

    thrpriv_fsm #(.IDX_W(IDX_W), .RAISE_IDX(2)) i_thrpriv_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_entry_i   (exc_entry_i),
        .exc_return_i  (exc_return_i),
        .svc_i         (svc_i),
        .svc_idx_i     (svc_idx_i),
        .ctl_wr_i      (ctl_wr_i),
        .ctl_unpriv_i  (ctl_unpriv_i),
        .mode_o        (mode_o),
        .priv_o        (priv_o),
        .thread_priv_o (thread_priv_o),
        .fault_o       (fault_o)
    );

    task automatic model_step(input logic en, input logic rt, input logic sv,
                              input logic [IDX_W-1:0] ix, input logic wr, input logic up);
        logic nm;
        logic nt;
        logic nf;
        nm = m_mode;
        nt = m_tp;
        nf = 1'b0;
        if (!m_mode) begin
            if (sv || en) begin
                nm = 1'b1;
                if (sv && ix == 8'd2) nt = 1'b1;
            end else if (wr) begin
                if (m_tp) nt = !up;
                else nf = 1'b1;
            end
        end else begin
            if (rt) nm = 1'b0;
            else if (wr) nt = !up;
        end
        m_mode  = nm;
        m_tp    = nt;
        m_fault = nf;
    endtask

    task automatic compare(input string tag);
        logic ep;
        ep = m_mode ? 1'b1 : m_tp;
        checks++;
        if (mode_o !== m_mode || thread_priv_o !== m_tp || priv_o !== ep || fault_o !== m_fault) begin
            errors++;
            $display("FAIL %s: got mode=%b tp=%b priv=%b fault=%b expected mode=%b tp=%b priv=%b fault=%b",
                     tag, mode_o, thread_priv_o, priv_o, fault_o, m_mode, m_tp, ep, m_fault);
        end
    endtask

    task automatic cyc(input logic en, input logic rt, input logic sv,
                       input logic [IDX_W-1:0] ix, input logic wr, input logic up,
                       input string tag);
        @(negedge clk);
        exc_entry_i  = en;
        exc_return_i = rt;
        svc_i        = sv;
        svc_idx_i    = ix;
        ctl_wr_i     = wr;
        ctl_unpriv_i = up;
        model_step(en, rt, sv, ix, wr, up);
        @(posedge clk);
        #2;
        compare(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        #2;
        compare("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, "R1 idle after reset");
        cyc(0, 0, 0, 0, 1, 0, "R4 priv write keep");
        cyc(0, 0, 0, 0, 1, 1, "R4 drop to user");
        cyc(0, 0, 0, 0, 1, 0, "R5 user write refused");
        cyc(0, 0, 0, 0, 0, 0, "R5 fault single pulse");
        cyc(1, 0, 0, 0, 0, 0, "R3 R2 entry keeps user level");
        cyc(1, 0, 1, 8'd2, 0, 0, "R10 entry ignored in handler");
        cyc(0, 1, 0, 0, 1, 0, "R10 return wins over write");
        cyc(0, 0, 1, 8'd5, 0, 0, "R7 other index");
        cyc(0, 1, 0, 0, 0, 0, "R7 return still user");
        cyc(0, 0, 1, 8'd2, 1, 1, "R6 R10 raise call drops write");
        cyc(0, 1, 0, 0, 0, 0, "R6 return privileged");
        cyc(0, 1, 0, 0, 0, 0, "R10 return ignored in thread");
        cyc(1, 0, 0, 0, 0, 0, "R3 entry privileged");
        cyc(0, 0, 0, 0, 1, 1, "R9 handler write lowers");
        cyc(0, 0, 0, 0, 1, 0, "R9 handler write raises");
        cyc(0, 1, 0, 0, 0, 0, "R3 return privileged");
        cyc(0, 0, 0, 0, 1, 1, "R8 user thread attr");
        for (int i = 0; i < 3000; i++) begin
            logic en;
            logic rt;
            logic sv;
            logic wr;
            logic up;
            logic [IDX_W-1:0] ix;
            en = ($urandom % 6) == 0;
            rt = ($urandom % 3) == 0;
            sv = ($urandom % 6) == 0;
            wr = ($urandom % 3) == 0;
            up = $urandom % 2;
            ix = (($urandom % 2) == 0) ? 8'd2 : 8'($urandom % 8);
            cyc(en, rt, sv, ix, wr, up, m_mode ? "R2 random handler" : "R8 random thread");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule